// File: doc/BRIEF.md
# Capture/Compare Interval Timer

The block is a free-running up-counter with a programmable power-of-two clock divider. When the counter passes its all-ones value it either restarts from a reload value or stops itself. A compare unit raises an event when the counter reaches a programmed value. The same counter is also sampled into one or two capture registers on selected edges of an external event input. A waveform output can flip its level on each timer event, or pulse away from its default level for one clock. While the timer is halted, the output rests at a programmed default level.

Software-facing logic sits outside the block. It reaches the block through a flat register port. Writes take effect on the next rising clock edge. Reads come back one cycle after the address is presented. The three raw event lines pulse for one cycle each, and masking them is left to the surrounding logic.

Top module: `capture_compare_timer`

## Requirements
- R1: After reset the control value, counter, capture values and read data are zero, and both the waveform output and all three raw event lines are low.
- R2: With control bit 0 (run) set and bit 5 (divider enable) clear, the counter rises by one on every clock edge. Writing address 1 loads the counter directly.
- R3: With bit 5 set, the counter advances once every 2^(D+1) clocks, where D is the 3-bit field at control bits 4:2.
- R4: Advancing from all-ones pulses raw event bit 1 (overflow) for one cycle. When control bit 1 (auto-reload) is set, the counter continues from the reload value (address 2).
- R5: On overflow with auto-reload clear, the counter becomes zero, control bit 0 clears itself, and the counter then holds.
- R6: Any write to address 3 copies the reload value into the counter on that edge.
- R7: With control bit 6 set, raw event bit 0 pulses for one cycle in the cycle the counter reaches the compare value (address 4). With bit 6 clear, that event never fires.
- R8: Control bits 11:10 select which events drive the waveform output: 0 none, 1 overflow only, 2 overflow or compare. With control bit 12 set, each selected event inverts the output.
- R9: With bit 12 clear, each selected event drives the output to the inverse of control bit 7 for one cycle. Otherwise the output sits at bit 7. While the timer is halted, the output equals bit 7.
- R10: Control bits 9:8 choose the capture edge on the synchronised event input: 0 off, 1 rising, 2 falling, 3 both. Each capture pulses raw event bit 2 in the third cycle after the input changes.
- R11: With control bit 13 clear, only the first selected edge after a control write is stored, in capture register 1 (address 5). Later edges are ignored.
- R12: With bit 13 set, the first selected edge after a control write is stored in capture register 1 and the second in capture register 2 (address 6). Further edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Registered read data, valid one cycle after rd_addr |
| evt_in | input | 1 | Asynchronous capture event input |
| pwm_out | output | 1 | Registered waveform output |
| raw_evt | output | 3 | Raw event pulses: bit 0 compare, bit 1 overflow, bit 2 capture |

## Verification
Several properties are checked on every clock by the bound checker. Each overflow must come from an all-ones counter and must land on the reload value or on zero with the run bit cleared. Each compare event must find the counter equal to the compare value with compare enabled. Undivided counting must rise by exactly one. Captures may only occur with an edge mode selected, and a halted timer must hold its default output level. The divider period, the trigger write, the toggle and pulse waveforms with their trigger selection, and the one-shot and two-stage capture sequences depend on multi-cycle stimulus. Only the bench scenarios show them, by comparing read-back values and output levels against cycle counts worked out in advance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 14;
  localparam int DIV_SEL_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_RELOAD = 3'd2,
    REG_TRIG   = 3'd3,
    REG_MATCH  = 3'd4,
    REG_CAP1   = 3'd5,
    REG_CAP2   = 3'd6
  } reg_addr_e;

  // control bit positions
  localparam int B_RUN     = 0;
  localparam int B_AUTO    = 1;
  localparam int B_DIV_LO  = 2;
  localparam int B_DIV_EN  = 5;
  localparam int B_CMP_EN  = 6;
  localparam int B_DEF_LVL = 7;
  localparam int B_EDGE_LO = 8;
  localparam int B_TRG_LO  = 10;
  localparam int B_TOGGLE  = 12;
  localparam int B_TWO_CAP = 13;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } cap_edge_e;

  typedef enum logic [1:0] {
    TRG_NONE    = 2'd0,
    TRG_OVF     = 2'd1,
    TRG_OVF_CMP = 2'd2,
    TRG_RSVD    = 2'd3
  } wave_trig_e;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider
  import tmr_pkg::*;
#(
  parameter int SEL_W = DIV_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             div_en,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) + 1;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;

  assign div_last = (DIV_W'(2) << div_sel) - DIV_W'(1);
  assign tick     = run && (!div_en || (div_cnt >= div_last));

  always_ff @(posedge clk) begin
    if (rst || !run || !div_en) begin
      div_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_in,
  input  cap_edge_e        edge_sel,
  input  logic             two_stage,
  input  logic             rearm,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap1,
  output logic [CNT_W-1:0] cap2,
  output logic             cap_evt
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall, hit;
  logic [1:0]        taken;

  assign rise = sync_q[SYNC_N-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_N-1] & prev_q;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      taken   <= 2'd0;
      cap1    <= '0;
      cap2    <= '0;
      cap_evt <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_N-2:0], evt_in};
      prev_q  <= sync_q[SYNC_N-1];
      cap_evt <= 1'b0;
      if (rearm) begin
        taken <= 2'd0;
      end else if (hit) begin
        if (taken == 2'd0) begin
          cap1    <= cnt;
          taken   <= 2'd1;
          cap_evt <= 1'b1;
        end else if (taken == 2'd1 && two_stage) begin
          cap2    <= cnt;
          taken   <= 2'd2;
          cap_evt <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       ovf_evt,
  input  logic       cmp_evt,
  input  wave_trig_e trig_sel,
  input  logic       toggle_mode,
  input  logic       def_lvl,
  output logic       wave_q
);
  logic fire;

  always_comb begin
    unique case (trig_sel)
      TRG_OVF:     fire = ovf_evt;
      TRG_OVF_CMP: fire = ovf_evt | cmp_evt;
      default:     fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
    end else if (fire) begin
      wave_q <= toggle_mode ? ~wave_q : ~def_lvl;
    end else if (!run || !toggle_mode) begin
      wave_q <= def_lvl;
    end
  end
endmodule

// File: rtl/capture_compare_timer.sv
module capture_compare_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              evt_in,
  output logic              pwm_out,
  output logic [2:0]        raw_evt
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, reload_q, match_q, cnt_nxt;
  logic [CNT_W-1:0]  cap1, cap2;
  logic [1:0]        evt_q;
  logic              cap_evt, tick;
  logic              wr_ctrl, wr_count, wr_trig, advance, at_top, ovf_nxt, cmp_nxt;

  assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
  assign wr_count = wr_en && (wr_addr == REG_COUNT);
  assign wr_trig  = wr_en && (wr_addr == REG_TRIG);

  tmr_divider #(.SEL_W(DIV_SEL_W)) div_i (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl_q[B_RUN]),
    .div_en (ctrl_q[B_DIV_EN]),
    .div_sel(ctrl_q[B_DIV_LO +: DIV_SEL_W]),
    .tick   (tick)
  );

  assign at_top  = &cnt_q;
  assign advance = tick && !wr_count && !wr_trig;
  assign ovf_nxt = advance && at_top;

  always_comb begin
    if (wr_count)      cnt_nxt = wr_data;
    else if (wr_trig)  cnt_nxt = reload_q;
    else if (advance)  cnt_nxt = at_top ? (ctrl_q[B_AUTO] ? reload_q : '0)
                                        : cnt_q + CNT_W'(1);
    else               cnt_nxt = cnt_q;
  end

  assign cmp_nxt = ctrl_q[B_CMP_EN] && advance && (cnt_nxt == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      reload_q <= '0;
      match_q  <= '0;
      evt_q    <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      evt_q <= {ovf_nxt, cmp_nxt};
      if (wr_ctrl) begin
        ctrl_q <= wr_data[CTRL_W-1:0];
      end else if (ovf_nxt && !ctrl_q[B_AUTO]) begin
        ctrl_q[B_RUN] <= 1'b0;
      end
      if (wr_en && wr_addr == REG_RELOAD) reload_q <= wr_data;
      if (wr_en && wr_addr == REG_MATCH)  match_q  <= wr_data;
    end
  end

  tmr_capture #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) cap_i (
    .clk      (clk),
    .rst      (rst),
    .evt_in   (evt_in),
    .edge_sel (cap_edge_e'(ctrl_q[B_EDGE_LO +: 2])),
    .two_stage(ctrl_q[B_TWO_CAP]),
    .rearm    (wr_ctrl),
    .cnt      (cnt_q),
    .cap1     (cap1),
    .cap2     (cap2),
    .cap_evt  (cap_evt)
  );

  tmr_wave wave_i (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl_q[B_RUN]),
    .ovf_evt    (ovf_nxt),
    .cmp_evt    (cmp_nxt),
    .trig_sel   (wave_trig_e'(ctrl_q[B_TRG_LO +: 2])),
    .toggle_mode(ctrl_q[B_TOGGLE]),
    .def_lvl    (ctrl_q[B_DEF_LVL]),
    .wave_q     (pwm_out)
  );

  assign raw_evt = {cap_evt, evt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_addr_e'(rd_addr))
        REG_CTRL:   rd_data <= CNT_W'(ctrl_q);
        REG_COUNT:  rd_data <= cnt_q;
        REG_RELOAD: rd_data <= reload_q;
        REG_MATCH:  rd_data <= match_q;
        REG_CAP1:   rd_data <= cap1;
        REG_CAP2:   rd_data <= cap2;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  match_q,
  input logic [2:0]        raw_evt,
  input logic              pwm_out
);
  // R2: undivided counting advances by one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[B_RUN] && !ctrl_q[B_DIV_EN] && !wr_en) && !raw_evt[1])
      |-> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R4: overflow only from all-ones, and auto-reload lands on reload value
  assert_ovf_from_top_R4: assert property (@(posedge clk) disable iff (rst)
    raw_evt[1] |-> &$past(cnt_q));

  assert_ovf_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (raw_evt[1] && $past(ctrl_q[B_AUTO])) |-> cnt_q == $past(reload_q));

  // R5: one-shot overflow stops at zero
  assert_ovf_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (raw_evt[1] && !$past(ctrl_q[B_AUTO]) && !$past(wr_en && wr_addr == REG_CTRL))
      |-> (cnt_q == '0) && !ctrl_q[B_RUN]);

  // R7: compare event needs compare enabled and counter at compare value
  assert_cmp_hit_R7: assert property (@(posedge clk) disable iff (rst)
    raw_evt[0] |-> (cnt_q == $past(match_q)) && $past(ctrl_q[B_CMP_EN]));

  // R9: halted timer rests at the default level
  assert_idle_level_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_q[B_RUN]) |-> pwm_out == $past(ctrl_q[B_DEF_LVL]));

  // R10: capture only with an edge mode selected
  assert_cap_mode_R10: assert property (@(posedge clk) disable iff (rst)
    raw_evt[2] |-> $past(ctrl_q[B_EDGE_LO +: 2]) != 2'b00);
endmodule

bind capture_compare_timer cct_checker #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ctrl_q  (ctrl_q),
  .cnt_q   (cnt_q),
  .reload_q(reload_q),
  .match_q (match_q),
  .raw_evt (raw_evt),
  .pwm_out (pwm_out)
);

// File: tb/capture_compare_timer_tb_top.sv
`timescale 1ns/1ps
module capture_compare_timer_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         evt_in = 1'b0;
  logic         pwm_out;
  logic [2:0]   raw_evt;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  string        tag_q[$];
  logic [W-1:0] act_q[$];
  logic [W-1:0] exp_q[$];

  always #5 clk = ~clk;

  capture_compare_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in),
    .pwm_out(pwm_out), .raw_evt(raw_evt)
  );

  // driver side: pushes observation and expectation into the scoreboard
  task automatic expect_eq(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tag_q.push_back(tag);
    act_q.push_back(act);
    exp_q.push_back(exp);
  endtask

  // monitor side: drains and compares
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      string        t;
      logic [W-1:0] a, e;
      t = tag_q.pop_front();
      a = act_q.pop_front();
      e = exp_q.pop_front();
      n_chk++;
      if (a !== e) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  // all tasks are entered at a falling edge and return at a falling edge
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); expect_eq("R1 ctrl", v, 0);
    rd(3'd1, v); expect_eq("R1 count", v, 0);
    rd(3'd5, v); expect_eq("R1 cap1", v, 0);
    expect_eq("R1 pwm", W'(pwm_out), 0);
    expect_eq("R1 events", W'(raw_evt), 0);

    // R2 undivided counting
    wr(3'd1, 32'd100);
    wr(3'd0, 32'h1);
    wait_n(8);
    wr(3'd0, 32'h0);
    rd(3'd1, v); expect_eq("R2 count after 9 clocks", v, 109);

    // R3 divide by 4 (select 1)
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h25);
    wait_n(20);
    wr(3'd0, 32'h0);
    rd(3'd1, v); expect_eq("R3 divided count", v, 5);

    // R4 overflow with auto-reload
    wr(3'd2, 32'h10);
    wr(3'd1, 32'hFFFF_FFFD);
    wr(3'd0, 32'h3);
    wait_n(2);
    expect_eq("R4 no event before wrap", W'(raw_evt), 0);
    wait_n(1);
    expect_eq("R4 overflow event", W'(raw_evt), 3'b010);
    wr(3'd0, 32'h0);
    expect_eq("R4 event one cycle", W'(raw_evt), 0);
    rd(3'd1, v); expect_eq("R4 reload continue", v, 32'h11);

    // R5 overflow without auto-reload
    wr(3'd1, 32'hFFFF_FFFE);
    wr(3'd0, 32'h1);
    wait_n(6);
    rd(3'd0, v); expect_eq("R5 run cleared", v, 0);
    rd(3'd1, v); expect_eq("R5 counter held at zero", v, 0);

    // R6 trigger write
    wr(3'd2, 32'h1234);
    wr(3'd3, 32'h0);
    rd(3'd1, v); expect_eq("R6 trigger copy", v, 32'h1234);

    // R7 compare enabled
    wr(3'd4, 32'd5);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h41);
    wait_n(4);
    expect_eq("R7 before match", W'(raw_evt), 0);
    wait_n(1);
    expect_eq("R7 match event", W'(raw_evt), 3'b001);
    wait_n(1);
    expect_eq("R7 match one cycle", W'(raw_evt), 0);
    wr(3'd0, 32'h0);
    // R7 compare disabled
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h1);
    wait_n(5);
    expect_eq("R7 no event without enable", W'(raw_evt[0]), 0);
    wr(3'd0, 32'h0);

    // R8 toggle on overflow or compare
    wr(3'd2, 32'hFFFF_FFF8);
    wr(3'd4, 32'hFFFF_FFFA);
    wr(3'd1, 32'hFFFF_FFF8);
    wr(3'd0, 32'h1843);
    wait_n(1);
    expect_eq("R8 pwm before match", W'(pwm_out), 0);
    wait_n(1);
    expect_eq("R8 toggle on match", W'(pwm_out), 1);
    wait_n(5);
    expect_eq("R8 level held", W'(pwm_out), 1);
    wait_n(1);
    expect_eq("R8 toggle on overflow", W'(pwm_out), 0);
    expect_eq("R8 overflow event", W'(raw_evt), 3'b010);
    wait_n(2);
    expect_eq("R8 toggle on next match", W'(pwm_out), 1);
    wr(3'd0, 32'h0);

    // R9 pulse on overflow only, default high
    wr(3'd1, 32'hFFFF_FFF8);
    wr(3'd0, 32'h4C3);
    wait_n(2);
    expect_eq("R9 match ignored by overflow trigger", W'(pwm_out), 1);
    expect_eq("R9 match still raised", W'(raw_evt), 3'b001);
    wait_n(5);
    expect_eq("R9 default before overflow", W'(pwm_out), 1);
    wait_n(1);
    expect_eq("R9 pulse low", W'(pwm_out), 0);
    wait_n(1);
    expect_eq("R9 pulse ends", W'(pwm_out), 1);
    wr(3'd0, 32'h80);
    wait_n(1);
    expect_eq("R9 halted default high", W'(pwm_out), 1);
    wr(3'd0, 32'h0);
    wait_n(1);
    expect_eq("R9 halted default low", W'(pwm_out), 0);

    // R10 rising capture, R11 single capture
    wr(3'd0, 32'h100);
    wr(3'd1, 32'h55);
    evt_in = 1'b1;
    wait_n(2);
    expect_eq("R10 no capture yet", W'(raw_evt), 0);
    wait_n(1);
    expect_eq("R10 capture event", W'(raw_evt), 3'b100);
    rd(3'd5, v); expect_eq("R10 cap1 value", v, 32'h55);
    evt_in = 1'b0;
    wait_n(4);
    wr(3'd1, 32'h66);
    evt_in = 1'b1;
    wait_n(4);
    rd(3'd5, v); expect_eq("R11 later edge ignored", v, 32'h55);
    rd(3'd6, v); expect_eq("R11 cap2 untouched", v, 0);

    // R10 falling-only selection
    wr(3'd0, 32'h200);
    wr(3'd1, 32'h77);
    evt_in = 1'b0;
    wait_n(4);
    rd(3'd5, v); expect_eq("R10 falling captured", v, 32'h77);
    wr(3'd0, 32'h200);
    wr(3'd1, 32'h88);
    evt_in = 1'b1;
    wait_n(4);
    rd(3'd5, v); expect_eq("R10 rising ignored", v, 32'h77);

    // R12 two-stage capture on both edges
    wr(3'd0, 32'h2300);
    wr(3'd1, 32'h70);
    evt_in = 1'b0;
    wait_n(4);
    wr(3'd1, 32'h80);
    evt_in = 1'b1;
    wait_n(4);
    wr(3'd1, 32'h90);
    evt_in = 1'b0;
    wait_n(4);
    rd(3'd5, v); expect_eq("R12 first edge", v, 32'h70);
    rd(3'd6, v); expect_eq("R12 second edge", v, 32'h80);

    wait_n(2);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule